// File: doc/BRIEF.md
# Fractional-Prescaled UART Baud Generator

This block turns a fast system clock into the two timing strobes a UART core needs: a sample enable at the oversampling rate and a bit enable at the serial bit rate. Both are enable pulses one system clock wide, not derived clocks. The clock rate is reduced in three stages, always in the same order. A fractional prescaler comes first, then a 16-bit integer divisor, then a programmable oversampling count. The resulting bit rate is clock / (SC × divisor × prescaler).

Software loads the divisor bytes, the prescaler byte, the prescaler enable and the oversampling field, then pulses `cfg_wr`. The strobe copies all of these values into shadow registers and restarts the generator, so the next pulse reflects the new setting with no left-over partial period.

A small control machine sequences the generator. It has three states:
- STOP: counters cleared, outputs quiet. This is the state after reset, or after a load with divisor 0.
- LOAD: a single clearing cycle entered on any `cfg_wr`.
- RUN: the generator counts.

The machine has four transitions:
- any state → LOAD on `cfg_wr`;
- LOAD → RUN when the divisor is non-zero;
- LOAD → STOP when the divisor is zero;
- RUN and STOP otherwise hold their state.

Top module: `frac_baud_gen`

## Requirements
- R1: The divisor is D = div_lo + 256·div_hi. With the prescaler bypassed, the n-th sample_en after a load is seen n·D cycles after the strobe edge.
- R2: A divisor of 0 keeps sample_en and bit_en low until the next load.
- R3: When psc_en is 0 the prescaler divides by 1, whatever psc_cfg holds.
- R4: With psc_en = 1, M = psc_cfg[7:3] and N = psc_cfg[2:0]. A 3-bit accumulator starts at 0 after a load. Each prescaler period lasts M+1 cycles when accumulator+N ≥ 8, and M cycles otherwise. The accumulator then becomes (accumulator+N) mod 8. Any 8 consecutive periods therefore total 8M+N cycles.
- R5: A prescaler integer field M of 0 acts as M = 1.
- R6: An sc_sel value from 4 to 15 gives SC = sc_sel. Values 0, 1, 2 and 3 give SC = 16.
- R7: bit_en is high only together with sample_en, on every SC-th sample_en after a load. Each pulse lasts one cycle.
- R8: In the cycle after a cfg_wr edge both outputs are low. Pulse timing then restarts from zero: the k-th prescaler tick falls in the cycle whose distance from the strobe edge equals the sum of the first k prescaler periods.
- R9: After reset, and before the first cfg_wr, both outputs stay low.
- R10: With the defaults (prescaler bypassed, SC = 16), divisor 12 gives a bit period of 192 cycles and divisor 1 gives 16 cycles. At a 1.8432 MHz clock these are 9600 and 115200 bit/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load strobe: captures the setting and restarts all counters |
| div_lo | input | 8 | Divisor low byte |
| div_hi | input | 8 | Divisor high byte |
| psc_cfg | input | 8 | Prescaler: [7:3] integer part, [2:0] eighths |
| psc_en | input | 1 | 1 uses the prescaler, 0 bypasses it |
| sc_sel | input | 4 | Oversampling ratio select |
| sample_en | output | 1 | One-cycle pulse at the oversampling rate |
| bit_en | output | 1 | One-cycle pulse at the bit rate |

## Verification
Every internal counter feeds the pulse times directly. A wrong accumulator step or a wrong modulus in the prescaler moves the first sample_en within at most eight prescaler periods. A divisor or oversampling counter that fails to wrap or clear shifts the first pulse after a load by whole periods. A missed clear on load shows as a short first interval. The bench therefore measures how many cycles after a load strobe the n-th pulse arrives, and compares this with a period sum computed from the requirements. It also checks that the outputs are quiet in the load cycle and with a zero divisor.

// File: rtl/baud_pkg.sv
package baud_pkg;
    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } gen_state_e;
endpackage

// File: rtl/frac_prescaler.sv
module frac_prescaler #(
    parameter int INT_W  = 5,
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              bypass,
    input  logic [INT_W-1:0]  m_int,
    input  logic [FRAC_W-1:0] n_frac,
    output logic              tick
);
    localparam int CNT_W = INT_W + 1;

    logic [CNT_W-1:0]  cnt;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   acc_sum;
    logic              carry;
    logic [CNT_W-1:0]  m_eff;
    logic [CNT_W-1:0]  len;
    logic              at_end;

    // Integer part 0 is promoted to 1 (R5)
    always_comb begin
        m_eff   = (m_int == '0) ? CNT_W'(1) : {1'b0, m_int};
        acc_sum = {1'b0, acc} + {1'b0, n_frac};
        carry   = acc_sum[FRAC_W];
        len     = m_eff + {{INT_W{1'b0}}, carry};
        at_end  = (cnt == len - CNT_W'(1));
        tick    = run && (bypass || at_end);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            acc <= '0;
        end else if (!bypass) begin
            if (at_end) begin
                cnt <= '0;
                acc <= acc_sum[FRAC_W-1:0];
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    p_cnt_in_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bypass) |-> (cnt < len));

    p_acc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bypass && !tick) |=> $stable(acc));

    p_bypass_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bypass) |=> (cnt == '0));
endmodule

// File: rtl/int_divider.sv
module int_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [DIV_W-1:0] divisor,
    output logic             pulse
);
    logic [DIV_W-1:0] cnt;
    logic             at_end;

    always_comb begin
        at_end = (divisor != '0) && (cnt == divisor - DIV_W'(1));
        pulse  = run && step && at_end;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (step) begin
            if (at_end) cnt <= '0;
            else        cnt <= cnt + DIV_W'(1);
        end
    end

    p_cnt_below_div_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && divisor != '0) |-> (cnt < divisor));

    p_idle_no_move_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !step) |=> $stable(cnt));
endmodule

// File: rtl/os_counter.sv
module os_counter #(
    parameter int SC_W   = 4,
    parameter int SC_MIN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            step,
    input  logic [SC_W-1:0] sc_field,
    output logic            pulse
);
    localparam int SCE_W  = SC_W + 1;
    localparam int SC_MAX = 1 << SC_W;

    logic [SCE_W-1:0] sc_eff;
    logic [SCE_W-1:0] cnt;
    logic             at_end;

    // Fields below the floor select the full ratio (R6)
    always_comb begin
        sc_eff = (sc_field < SC_W'(SC_MIN)) ? SCE_W'(SC_MAX) : {1'b0, sc_field};
        at_end = (cnt == sc_eff - SCE_W'(1));
        pulse  = run && step && at_end;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (step) begin
            if (at_end) cnt <= '0;
            else        cnt <= cnt + SCE_W'(1);
        end
    end

    p_sc_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < sc_eff && sc_eff >= SCE_W'(SC_MIN)));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import baud_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int INT_W  = 5,
    parameter int FRAC_W = 3,
    parameter int SC_W   = 4,
    parameter int SC_MIN = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [DIV_W/2-1:0]     div_lo,
    input  logic [DIV_W/2-1:0]     div_hi,
    input  logic [INT_W+FRAC_W-1:0] psc_cfg,
    input  logic                   psc_en,
    input  logic [SC_W-1:0]        sc_sel,
    output logic                   sample_en,
    output logic                   bit_en
);
    localparam int PSC_W = INT_W + FRAC_W;

    gen_state_e       state;
    gen_state_e       state_nx;
    logic [DIV_W-1:0] div_sh;
    logic [PSC_W-1:0] psc_sh;
    logic             pe_sh;
    logic [SC_W-1:0]  sc_sh;
    logic             run;
    logic             psc_tick;

    // Shadow copy of the setting, taken on the load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_sh <= '0;
            psc_sh <= '0;
            pe_sh  <= 1'b0;
            sc_sh  <= '0;
        end else if (cfg_wr) begin
            div_sh <= {div_hi, div_lo};
            psc_sh <= psc_cfg;
            pe_sh  <= psc_en;
            sc_sh  <= sc_sel;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_STOP;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        if (cfg_wr) begin
            state_nx = ST_LOAD;
        end else begin
            unique case (state)
                ST_LOAD: state_nx = (div_sh == '0) ? ST_STOP : ST_RUN;
                ST_RUN:  state_nx = ST_RUN;
                ST_STOP: state_nx = ST_STOP;
                default: state_nx = ST_STOP;
            endcase
        end
    end

    // Outputs of the control machine
    always_comb begin
        run = 1'b0;
        unique case (state)
            ST_RUN:  run = 1'b1;
            ST_LOAD: run = 1'b0;
            ST_STOP: run = 1'b0;
            default: run = 1'b0;
        endcase
    end

    frac_prescaler #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .bypass (!pe_sh),
        .m_int  (psc_sh[PSC_W-1:FRAC_W]),
        .n_frac (psc_sh[FRAC_W-1:0]),
        .tick   (psc_tick)
    );

    int_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .step    (psc_tick),
        .divisor (div_sh),
        .pulse   (sample_en)
    );

    os_counter #(.SC_W(SC_W), .SC_MIN(SC_MIN)) u_os (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .step     (sample_en),
        .sc_field (sc_sh),
        .pulse    (bit_en)
    );

    p_stop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP) |-> (!sample_en && !bit_en));

    p_load_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!sample_en && !bit_en));

    p_bit_with_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |-> sample_en);

    p_sample_needs_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> psc_tick);
endmodule

// File: tb/test_frac_baud_gen.sv
`timescale 1ns/1ps
module test_frac_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] div_lo = '0;
    logic [7:0] div_hi = '0;
    logic [7:0] psc_cfg = '0;
    logic       psc_en = 1'b0;
    logic [3:0] sc_sel = '0;
    logic       sample_en;
    logic       bit_en;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    frac_baud_gen i_frac_baud_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .div_lo    (div_lo),
        .div_hi    (div_hi),
        .psc_cfg   (psc_cfg),
        .psc_en    (psc_en),
        .sc_sel    (sc_sel),
        .sample_en (sample_en),
        .bit_en    (bit_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Sum of the first cnt prescaler periods after a load
    function automatic int psc_sum(input bit pe, input int m, input int n, input int cnt);
        int me;
        int acc;
        int s;
        if (!pe) return cnt;
        me  = (m == 0) ? 1 : m;
        acc = 0;
        s   = 0;
        for (int i = 0; i < cnt; i++) begin
            s  += me + (((acc + n) >= 8) ? 1 : 0);
            acc = (acc + n) % 8;
        end
        return s;
    endfunction

    function automatic int sc_of(input int f);
        return (f < 4) ? 16 : f;
    endfunction

    task automatic wr_cfg(input int d, input int p, input bit pe, input int sc);
        @(negedge clk);
        div_lo  = d[7:0];
        div_hi  = d[15:8];
        psc_cfg = p[7:0];
        psc_en  = pe;
        sc_sel  = sc[3:0];
        cfg_wr  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
        chk("R8 load cycle quiet", int'(sample_en | bit_en), 0);
    endtask

    // Cycles from the strobe edge to the n-th pulse
    task automatic measure(input bit use_bit, input int n, output int k);
        int seen = 0;
        k = 0;
        while (seen < n && k < 20000) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (use_bit ? bit_en : sample_en) seen++;
        end
        if (seen < n) k = -1;
    endtask

    task automatic count_pulses(input int cycles, output int ns, output int nb);
        ns = 0;
        nb = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sample_en) ns++;
            if (bit_en) nb++;
        end
    endtask

    task automatic t_reset;
        int ns;
        int nb;
        count_pulses(40, ns, nb);
        chk("R9 reset sample quiet", ns, 0);
        chk("R9 reset bit quiet", nb, 0);
    endtask

    task automatic t_default_rates;
        int k;
        wr_cfg(12, 0, 0, 0);
        measure(0, 1, k);
        chk("R1 first sample D=12", k, 12);
        wr_cfg(12, 0, 0, 0);
        measure(1, 2, k);
        chk("R10 two bits at 9600 setting", k, 384);
        wr_cfg(1, 0, 0, 0);
        measure(1, 1, k);
        chk("R10 bit at 115200 setting", k, 16);
    endtask

    task automatic t_high_byte;
        int k;
        wr_cfg(16'h0102, 0, 0, 0);
        measure(0, 2, k);
        chk("R1 high byte divisor", k, 2 * 258);
    endtask

    task automatic t_sc_modes;
        int k;
        int f[6] = '{4, 7, 15, 0, 1, 3};
        foreach (f[i]) begin
            wr_cfg(3, 0, 0, f[i]);
            measure(1, 1, k);
            chk($sformatf("R6 sc field %0d", f[i]), k, 3 * sc_of(f[i]));
        end
    endtask

    task automatic t_prescaler;
        int k;
        wr_cfg(1, (2 << 3) | 3, 1, 0);
        measure(0, 1, k);
        chk("R4 first period M=2 N=3", k, psc_sum(1, 2, 3, 1));
        wr_cfg(1, (2 << 3) | 3, 1, 0);
        measure(0, 8, k);
        chk("R4 eight periods M=2 N=3", k, 19);
        wr_cfg(1, (3 << 3), 1, 0);
        measure(0, 3, k);
        chk("R4 integer only M=3", k, 9);
        wr_cfg(3, (5 << 3) | 7, 1, 4);
        measure(1, 1, k);
        chk("R4 bit M=5 N=7 D=3 SC=4", k, psc_sum(1, 5, 7, 12));
        wr_cfg(2, (31 << 3) | 5, 1, 4);
        measure(0, 4, k);
        chk("R4 max integer M=31 N=5", k, psc_sum(1, 31, 5, 8));
    endtask

    task automatic t_bypass;
        int k;
        wr_cfg(4, 8'h13, 0, 0);
        measure(0, 2, k);
        chk("R3 prescaler ignored when disabled", k, 8);
    endtask

    task automatic t_zero_int;
        int k;
        wr_cfg(6, 8'h00, 1, 0);
        measure(0, 1, k);
        chk("R5 zero integer acts as one", k, 6);
        wr_cfg(4, 8'h02, 1, 0);
        measure(0, 4, k);
        chk("R5 zero integer with fraction", k, psc_sum(1, 0, 2, 16));
    endtask

    task automatic t_div_zero;
        int ns;
        int nb;
        int k;
        wr_cfg(0, 0, 0, 4);
        count_pulses(100, ns, nb);
        chk("R2 zero divisor sample quiet", ns, 0);
        chk("R2 zero divisor bit quiet", nb, 0);
        wr_cfg(2, 0, 0, 4);
        measure(1, 1, k);
        chk("R2 restart after zero divisor", k, 8);
    endtask

    task automatic t_restart;
        int k;
        wr_cfg(5, 0, 0, 0);
        repeat (7) @(posedge clk);
        wr_cfg(5, 0, 0, 0);
        measure(0, 1, k);
        chk("R8 no partial period after reload", k, 5);
        wr_cfg(3, (2 << 3) | 6, 1, 0);
        repeat (4) @(posedge clk);
        wr_cfg(3, (2 << 3) | 6, 1, 0);
        measure(0, 1, k);
        chk("R8 accumulator cleared on reload", k, psc_sum(1, 2, 6, 3));
    endtask

    task automatic t_pulse_counts;
        int ns;
        int nb;
        wr_cfg(2, 0, 0, 4);
        count_pulses(80, ns, nb);
        chk("R7 sample pulses in 80 cycles", ns, 40);
        chk("R7 bit pulses on every fourth sample", nb, 10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_default_rates();
        t_high_byte();
        t_sc_modes();
        t_prescaler();
        t_bypass();
        t_zero_int();
        t_div_zero();
        t_restart();
        t_pulse_counts();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule